// File: doc/BRIEF.md
# Character Display Power-Up Initializer

This block brings a character display controller out of power-up in 8-bit bus mode. After reset it waits a fixed time for the display supply to settle. It then sends five instruction bytes in a fixed order: two identical function-set bytes, a display-control byte, a clear byte and an entry-mode byte. Each byte goes to a separate transfer engine through a request/done handshake. The engine handles the bus timing of the actual write.

Between the instructions the sequencer waits a fixed number of clock cycles and never reads the display's busy state. Each wait starts on the done pulse of the transfer before it. After the last transfer the block raises `ready`. A `start` pulse given while ready runs the whole sequence again, power-up wait included.

The line count, font, display/cursor/blink enables and entry direction/shift come from configuration inputs. These inputs are sampled during the power-up wait and then held for the rest of the sequence.

The state machine has these states:
- S_PWR_WAIT: power-up wait.
- S_FSET_A / S_FSET_B: the first and second function set.
- S_DISP: display control.
- S_CLEAR: clear.
- S_ENTRY: entry mode.
- S_GAP_A, S_GAP_B, S_GAP_C and S_GAP_D: the timed waits after the first four transfers.
- S_READY: sequence complete.

Its transitions are:
- S_PWR_WAIT to S_FSET_A when the timer expires.
- Each send state to the next wait state on `xfer_done`.
- Each wait state to the next send state when the timer expires.
- S_ENTRY to S_READY on `xfer_done`.
- S_READY back to S_PWR_WAIT on `start`.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is held, `xfer_req` and `ready` are 0. After reset is released, the first `xfer_req` rises exactly PWR_CYC clock edges after the last edge at which reset was sampled low.
- R2: The five transfers come in the order function set, function set, display control, clear, entry mode. The function-set byte is 0x30 with bit 3 = two-line select and bit 2 = large-font select.
- R3: The display-control byte is 0x08 with bit 2 = display on, bit 1 = cursor on and bit 0 = blink on.
- R4: The clear byte is 0x01.
- R5: The entry-mode byte is 0x04 with bit 1 = increment direction and bit 0 = display shift.
- R6: Once `xfer_req` is high, it stays high with `xfer_cmd` unchanged until `xfer_done` is sampled high. A `xfer_done` sampled while `xfer_req` is low has no effect on the sequence.
- R7: After the done edge of the first, second, third and fourth transfer, `xfer_req` is low for exactly GAP_A, GAP_B, GAP_C and GAP_D cycles respectively, and then rises with the next byte.
- R8: `ready` is 1 from the edge that samples the done of the entry-mode transfer. It stays 1, with `xfer_req` low, until a start or a reset.
- R9: A `start` sampled while ready clears `ready` at that edge and restarts the sequence from the power-up wait, with the first request PWR_CYC edges later. A `start` sampled while the sequence is running is ignored.
- R10: The configuration inputs are captured on every edge during the power-up wait. All five bytes use the value held at the edge that ends the wait, and later changes are ignored until the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart request, honoured only while ready |
| cfg_two_line | input | 1 | Two-line display select |
| cfg_big_font | input | 1 | Large font select |
| cfg_disp_on | input | 1 | Display enable |
| cfg_cursor_on | input | 1 | Cursor enable |
| cfg_blink_on | input | 1 | Cursor blink enable |
| cfg_incr | input | 1 | Address increments after each write |
| cfg_shift | input | 1 | Whole display shifts on writes |
| xfer_req | output | 1 | Instruction transfer request, held until done |
| xfer_cmd | output | 8 | Instruction byte to write |
| xfer_done | input | 1 | One-cycle completion pulse from the transfer engine |
| ready | output | 1 | Initialization complete |

## Verification
The bench builds the block with PWR_CYC = 20, GAP_A = 6, GAP_B = 4, GAP_C = 3 and GAP_D = 9. Because all five waits are short and distinct, any swapped, shortened or mis-started wait shows up as a wrong cycle count, and the bench can run three complete sequences.

The bench varies the engine's done latency from 0 to 3 cycles, which tests whether each wait starts on the done edge. It also injects stray done pulses inside the waits, a start pulse in mid-sequence, and configuration changes both during and after the power-up wait. The minimum gap of 3 leaves room for a stray done to land inside a wait.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

    typedef enum logic [3:0] {
        S_PWR_WAIT,
        S_FSET_A,
        S_GAP_A,
        S_FSET_B,
        S_GAP_B,
        S_DISP,
        S_GAP_C,
        S_CLEAR,
        S_GAP_D,
        S_ENTRY,
        S_READY
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_FSET,
        CMD_DISP,
        CMD_CLEAR,
        CMD_ENTRY
    } cmd_sel_t;

    typedef struct packed {
        logic two_line;
        logic big_font;
        logic disp_on;
        logic cursor_on;
        logic blink_on;
        logic incr;
        logic shift;
    } lcd_cfg_t;

endpackage

// File: rtl/lcd_init_timer.sv
module lcd_init_timer #(
    parameter int unsigned CNT_W   = 8,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Down counter: a load of N-1 expires after N edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/lcd_init_cfg_reg.sv
module lcd_init_cfg_reg
    import lcd_init_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture,
    input  lcd_cfg_t cfg_d,
    output lcd_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/lcd_init_cmd_enc.sv
module lcd_init_cmd_enc
    import lcd_init_pkg::*;
(
    input  cmd_sel_t   sel,
    input  lcd_cfg_t   cfg,
    output logic [7:0] cmd
);

    always_comb begin
        unique case (sel)
            CMD_FSET:  cmd = {4'b0011, cfg.two_line, cfg.big_font, 2'b00};
            CMD_DISP:  cmd = {5'b00001, cfg.disp_on, cfg.cursor_on, cfg.blink_on};
            CMD_CLEAR: cmd = 8'h01;
            CMD_ENTRY: cmd = {6'b000001, cfg.incr, cfg.shift};
            default:   cmd = 8'h00;
        endcase
    end

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
    import lcd_init_pkg::*;
#(
    parameter int unsigned PWR_CYC = 2_100_000,
    parameter int unsigned GAP_A   = 2_000,
    parameter int unsigned GAP_B   = 1_900,
    parameter int unsigned GAP_C   = 1_900,
    parameter int unsigned GAP_D   = 80_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cfg_two_line,
    input  logic       cfg_big_font,
    input  logic       cfg_disp_on,
    input  logic       cfg_cursor_on,
    input  logic       cfg_blink_on,
    input  logic       cfg_incr,
    input  logic       cfg_shift,
    output logic       xfer_req,
    output logic [7:0] xfer_cmd,
    input  logic       xfer_done,
    output logic       ready
);

    localparam int unsigned MAX_AB  = (GAP_A > GAP_B) ? GAP_A : GAP_B;
    localparam int unsigned MAX_CD  = (GAP_C > GAP_D) ? GAP_C : GAP_D;
    localparam int unsigned MAX_G   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned MAX_ALL = (PWR_CYC > MAX_G) ? PWR_CYC : MAX_G;
    localparam int unsigned CNT_W   = ($clog2(MAX_ALL) < 1) ? 1 : $clog2(MAX_ALL);

    localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(PWR_CYC - 1);
    localparam logic [CNT_W-1:0] LD_A   = CNT_W'(GAP_A - 1);
    localparam logic [CNT_W-1:0] LD_B   = CNT_W'(GAP_B - 1);
    localparam logic [CNT_W-1:0] LD_C   = CNT_W'(GAP_C - 1);
    localparam logic [CNT_W-1:0] LD_D   = CNT_W'(GAP_D - 1);

    seq_state_t       state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             cfg_capture;
    cmd_sel_t         cmd_sel;
    lcd_cfg_t         cfg_in, cfg_held;

    assign cfg_in = '{two_line:  cfg_two_line,
                      big_font:  cfg_big_font,
                      disp_on:   cfg_disp_on,
                      cursor_on: cfg_cursor_on,
                      blink_on:  cfg_blink_on,
                      incr:      cfg_incr,
                      shift:     cfg_shift};

    lcd_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (LD_PWR)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    lcd_init_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cfg_capture),
        .cfg_d   (cfg_in),
        .cfg_q   (cfg_held)
    );

    lcd_init_cmd_enc u_enc (
        .sel (cmd_sel),
        .cfg (cfg_held),
        .cmd (xfer_cmd)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_PWR_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_PWR_WAIT: if (tmr_zero) state_d = S_FSET_A;
            S_FSET_A: if (xfer_done) begin
                state_d  = S_GAP_A;
                tmr_load = 1'b1;
                tmr_val  = LD_A;
            end
            S_GAP_A: if (tmr_zero) state_d = S_FSET_B;
            S_FSET_B: if (xfer_done) begin
                state_d  = S_GAP_B;
                tmr_load = 1'b1;
                tmr_val  = LD_B;
            end
            S_GAP_B: if (tmr_zero) state_d = S_DISP;
            S_DISP: if (xfer_done) begin
                state_d  = S_GAP_C;
                tmr_load = 1'b1;
                tmr_val  = LD_C;
            end
            S_GAP_C: if (tmr_zero) state_d = S_CLEAR;
            S_CLEAR: if (xfer_done) begin
                state_d  = S_GAP_D;
                tmr_load = 1'b1;
                tmr_val  = LD_D;
            end
            S_GAP_D: if (tmr_zero) state_d = S_ENTRY;
            S_ENTRY: if (xfer_done) state_d = S_READY;
            S_READY: if (start) begin
                state_d  = S_PWR_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_PWR;
            end
            default: state_d = S_PWR_WAIT;
        endcase
    end

    // Moore outputs
    always_comb begin
        xfer_req    = 1'b0;
        cmd_sel     = CMD_NONE;
        ready       = 1'b0;
        cfg_capture = 1'b0;
        unique case (state_q)
            S_PWR_WAIT: cfg_capture = 1'b1;
            S_FSET_A, S_FSET_B: begin
                xfer_req = 1'b1;
                cmd_sel  = CMD_FSET;
            end
            S_DISP: begin
                xfer_req = 1'b1;
                cmd_sel  = CMD_DISP;
            end
            S_CLEAR: begin
                xfer_req = 1'b1;
                cmd_sel  = CMD_CLEAR;
            end
            S_ENTRY: begin
                xfer_req = 1'b1;
                cmd_sel  = CMD_ENTRY;
            end
            S_READY: ready = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       xfer_req,
    input logic [7:0] xfer_cmd,
    input logic       xfer_done,
    input logic       ready
);

    // R6: request and byte hold until done
    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done |=> xfer_req && $stable(xfer_cmd));

    // R7: every accepted transfer is followed by at least one idle cycle
    p_gap_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done |=> !xfer_req);

    // R8: no transfer while ready
    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !xfer_req);

    // R8: ready holds without start
    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !start |=> ready);

    // R9: ready only drops because of start
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(start));

    // R2: only the four legal instruction shapes are requested
    p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> ((xfer_cmd[7:4] == 4'h3 && xfer_cmd[1:0] == 2'b00) ||
                      xfer_cmd[7:3] == 5'b00001 ||
                      xfer_cmd == 8'h01 ||
                      xfer_cmd[7:2] == 6'b000001));

endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .xfer_req  (xfer_req),
    .xfer_cmd  (xfer_cmd),
    .xfer_done (xfer_done),
    .ready     (ready)
);

// File: tb/lcd_init_seq_tb_top.sv
module lcd_init_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P_PWR = 20;
    localparam int P_A   = 6;
    localparam int P_B   = 4;
    localparam int P_C   = 3;
    localparam int P_D   = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] cfg = '0; // {two_line, big_font, disp_on, cursor_on, blink_on, incr, shift}
    logic       xfer_req;
    logic [7:0] xfer_cmd;
    logic       xfer_done = 1'b0;
    logic       ready;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_init_seq #(
        .PWR_CYC (P_PWR),
        .GAP_A   (P_A),
        .GAP_B   (P_B),
        .GAP_C   (P_C),
        .GAP_D   (P_D)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cfg_two_line  (cfg[6]),
        .cfg_big_font  (cfg[5]),
        .cfg_disp_on   (cfg[4]),
        .cfg_cursor_on (cfg[3]),
        .cfg_blink_on  (cfg[2]),
        .cfg_incr      (cfg[1]),
        .cfg_shift     (cfg[0]),
        .xfer_req      (xfer_req),
        .xfer_cmd      (xfer_cmd),
        .xfer_done     (xfer_done),
        .ready         (ready)
    );

    typedef struct {
        logic [7:0] cmd;
        int         gap;
        bit         last;
        string      ctag;
        string      gtag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   ref_cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    int   xfer_n = 0;
    bit   seq_done = 1'b0;
    bit   summary_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
                     tag, act, act, exp, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    // Driver: push the expected five transfers for one configuration
    task automatic push_seq(input logic [6:0] c);
        exp_t it;
        it.last = 1'b0;
        it.cmd = {4'b0011, c[6], c[5], 2'b00}; it.gap = P_PWR; it.ctag = "R2"; it.gtag = "R1";
        exp_q.push_back(it);
        it.gap = P_A; it.ctag = "R2"; it.gtag = "R7";
        exp_q.push_back(it);
        it.cmd = {5'b00001, c[4], c[3], c[2]}; it.gap = P_B; it.ctag = "R3";
        exp_q.push_back(it);
        it.cmd = 8'h01; it.gap = P_C; it.ctag = "R4";
        exp_q.push_back(it);
        it.cmd = {6'b000001, c[1], c[0]}; it.gap = P_D; it.ctag = "R5"; it.last = 1'b1;
        exp_q.push_back(it);
    endtask

    task automatic pulse_start(input bit counts);
        @(negedge clk);
        start = 1'b1;
        if (counts) ref_cyc = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: acts as transfer engine and scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && xfer_req) begin
                int   lat;
                bit   spur;
                exp_t it;
                logic [7:0] held;
                lat  = xfer_n % 4;
                spur = (xfer_n % 2) == 1;
                xfer_n++;
                held = xfer_cmd;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected request", int'(xfer_cmd), 0);
                    it.last = 1'b0;
                end else begin
                    it = exp_q.pop_front();
                    chk(xfer_cmd == it.cmd, it.ctag, int'(xfer_cmd), int'(it.cmd));
                    chk((cyc - ref_cyc) == it.gap, it.gtag, cyc - ref_cyc, it.gap);
                end
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    chk(xfer_req && xfer_cmd == held, "R6 hold",
                        int'({xfer_req, xfer_cmd}), int'({1'b1, held}));
                end
                xfer_done = 1'b1;
                ref_cyc = cyc + 1;
                @(negedge clk);
                xfer_done = 1'b0;
                if (it.last) begin
                    chk(ready == 1'b1 && !xfer_req, "R8 ready after last",
                        int'({ready, xfer_req}), 2);
                    seq_done = 1'b1;
                end else begin
                    chk(!xfer_req, "R7 request drops", int'(xfer_req), 0);
                end
                if (spur) begin
                    // R6: stray done inside a wait must not move the schedule
                    @(negedge clk);
                    xfer_done = 1'b1;
                    @(negedge clk);
                    xfer_done = 1'b0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // Sequence 1, reset state (R1)
        rst_n = 1'b0;
        cfg = 7'b1010110;
        repeat (3) @(negedge clk);
        chk(!xfer_req, "R1 reset req", int'(xfer_req), 0);
        chk(!ready, "R1 reset ready", int'(ready), 0);
        push_seq(7'b1010110);
        rst_n = 1'b1;
        ref_cyc = cyc;
        // After two transfers: change config (R10) and try a start (R9 ignored)
        wait (exp_q.size() == 3);
        @(negedge clk);
        cfg = 7'b0101001;
        pulse_start(1'b0);
        wait (seq_done);
        seq_done = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(ready && !xfer_req, "R8 ready sticky", int'({ready, xfer_req}), 2);
        end

        // Sequence 2: restart, config changed during power-up wait (R9, R10)
        cfg = 7'b0000000;
        pulse_start(1'b1);
        chk(!ready, "R9 ready cleared", int'(ready), 1'b0);
        repeat (5) @(negedge clk);
        cfg = 7'b0111001;
        push_seq(7'b0111001);
        wait (seq_done);
        seq_done = 1'b0;
        repeat (4) @(negedge clk);

        // Sequence 3: all options set
        cfg = 7'b1111111;
        push_seq(7'b1111111);
        pulse_start(1'b1);
        wait (seq_done);
        seq_done = 1'b0;
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all transfers seen", exp_q.size(), 0);
        chk(ready && !xfer_req, "R8 final ready", int'({ready, xfer_req}), 2);
        summary();
        $finish;
    end

endmodule